// File: doc/BRIEF.md
# Bus-Mastering Block Transfer Engine

This engine moves a programmed number of bytes between an I/O device and memory while the CPU is off the bus. Software writes a source address, a destination address, a byte count and a control word through a small write-only register port. The control word starts the engine and selects how it holds the bus and how each byte travels. The engine asks the CPU for the bus with a hold request. It waits for the hold acknowledge, then runs its bus cycles. Each moved byte steps the addresses and lowers the count. When the count reaches zero the engine raises a sticky interrupt.

There are two ways to hold the bus. In cycle-steal mode the engine gives the bus back after every byte. In burst mode it keeps the bus until the last byte has moved. There are also two ways to move a byte. In fly-by mode the byte goes straight between the device and memory in one bus cycle, marked by the device acknowledge line; the destination register holds the memory address. In two-cycle mode the engine reads a byte from the source, keeps it internally and writes it to the destination in the next cycle. Each side of a two-cycle transfer can step or stay fixed, so that side can be a port.

Top module: `dma_mover`

## Requirements
- R1: After reset, `hold_req`, `irq`, `busy`, `bus_rd`, `bus_wr` and `dev_ack` are low. `bus_rd`, `bus_wr` and `dev_ack` are only high while both `hold_req` and `hold_ack` are high.
- R2: Cycle-steal mode is control bit 1 = 0. In this mode `hold_req` falls in the cycle after each byte's last bus cycle, so a block of N bytes takes N separate grants.
- R3: Burst mode is control bit 1 = 1. In this mode `hold_req` stays high from the grant until the last byte, so a block takes exactly one grant.
- R4: Fly-by mode is control bit 2 = 0. Each byte is one cycle with `dev_ack` high and `bus_addr` set to the destination register plus the byte index. Control bit 5 = 1 sends the byte to memory and pulses `bus_wr`. Bit 5 = 0 reads memory and pulses `bus_rd`. `bus_wdata` is 0 in this mode.
- R5: Two-cycle mode is control bit 2 = 1. Each byte is a `bus_rd` cycle at the source address, followed in the next cycle by a `bus_wr` cycle at the destination address. The write drives `bus_wdata` with the byte just read, and `dev_ack` stays low in both cycles.
- R6: In two-cycle mode, control bit 3 = 1 steps the source address by one per byte and bit 3 = 0 keeps it fixed. Bit 4 does the same for the destination address.
- R7: The count drops by one per byte moved. When it reaches zero the engine releases the bus, `busy` falls and `irq` rises, with exactly the programmed number of bus transfers done.
- R8: `irq` stays high until a control write (select 3) with bit 7 set.
- R9: A start (control write with bit 0 set) while the count register is 0 raises `irq` at the clock edge of that write and performs no grant and no bus cycle.
- R10: Register selects are 0 = source, 1 = destination, 2 = count and 3 = control. While `busy` is high, address and count writes are ignored, and so is a control write's start and mode.
- R11: In fly-by mode the engine requests the bus only while `dev_req` is high. In cycle-steal mode, if `dev_req` is low when the bus is owned, the engine releases the bus and waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | REG_W | Register write data |
| irq | output | 1 | Completion interrupt, sticky |
| busy | output | 1 | Transfer in progress |
| hold_req | output | 1 | Bus ownership request to the CPU |
| hold_ack | input | 1 | Bus ownership granted by the CPU |
| dev_req | input | 1 | Device asks for a fly-by transfer |
| dev_ack | output | 1 | Fly-by cycle marker to the device |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd | output | 1 | Memory/port read strobe |
| bus_wr | output | 1 | Memory/port write strobe |
| bus_wdata | output | DATA_W | Write data of two-cycle transfers |
| bus_rdata | input | DATA_W | Read data from the bus |

## Verification
The assertions check on every cycle that strobes appear only under a granted bus. They also check that the bus is released after each byte in cycle-steal mode and kept between bytes in burst mode. The remaining per-cycle checks cover the count stepping, fixed addresses staying put, the interrupt staying high and zero-count starts finishing at once. Only the bench's scenarios can show the full picture. They show the exact order of addresses and data over a whole block and the number of grants per block. They also show that writes during a transfer leave it undisturbed, and that a fly-by transfer stalls until the device asks.

// File: rtl/dma_mover_pkg.sv
`timescale 1ns/1ps
package dma_mover_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_WAIT, ST_ARB, ST_FLY, ST_RD, ST_WR, ST_REL
   } dma_state_t;

   typedef struct packed {
      logic burst;
      logic two_step;
      logic src_inc;
      logic dst_inc;
      logic to_mem;
   } dma_mode_t;

   localparam int CB_GO    = 0;
   localparam int CB_BURST = 1;
   localparam int CB_TWO   = 2;
   localparam int CB_SINC  = 3;
   localparam int CB_DINC  = 4;
   localparam int CB_TOMEM = 5;
   localparam int CB_CLR   = 7;

   localparam logic [1:0] SEL_SRC = 2'd0;
   localparam logic [1:0] SEL_DST = 2'd1;
   localparam logic [1:0] SEL_CNT = 2'd2;
   localparam logic [1:0] SEL_CTL = 2'd3;
endpackage

// File: rtl/dma_mover_ctl.sv
`timescale 1ns/1ps
module dma_mover_ctl
   import dma_mover_pkg::*;
#(
   parameter int REG_W        = 16,
   parameter bit HAS_TWO_STEP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [1:0]       reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             busy,
   input  logic             cnt_zero,
   input  logic             done,
   output logic             start,
   output dma_mode_t        mode,
   output logic             irq
);
   logic ctl_wr, go, zero_go, two_bit;

   if (REG_W < 8) begin : g_bad_reg_w
      $error("dma_mover_ctl: REG_W must hold the 8-bit control word");
   end

   if (HAS_TWO_STEP) begin : g_two_step
      assign two_bit = reg_wdata[CB_TWO];
   end else begin : g_fly_only
      assign two_bit = 1'b0;
   end

   assign ctl_wr  = reg_we && (reg_sel == SEL_CTL);
   assign go      = ctl_wr && reg_wdata[CB_GO] && !busy;
   assign start   = go && !cnt_zero;
   assign zero_go = go && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
         irq  <= 1'b0;
      end else begin
         if (go) begin
            mode.burst    <= reg_wdata[CB_BURST];
            mode.two_step <= two_bit;
            mode.src_inc  <= reg_wdata[CB_SINC];
            mode.dst_inc  <= reg_wdata[CB_DINC];
            mode.to_mem   <= reg_wdata[CB_TOMEM];
         end
         if (done || zero_go)
            irq <= 1'b1;
         else if (ctl_wr && reg_wdata[CB_CLR])
            irq <= 1'b0;
      end
   end

   assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(ctl_wr && reg_wdata[CB_CLR])) |=> irq);

   assert_zero_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      zero_go |=> (irq && !busy));

   assert_busy_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && busy) |=> $stable(mode));
endmodule

// File: rtl/dma_mover_addr.sv
`timescale 1ns/1ps
module dma_mover_addr #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_src,
   input  logic              load_dst,
   input  logic              load_cnt,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic              step_fly,
   input  logic              step_rd,
   input  logic              step_wr,
   input  logic              src_inc,
   input  logic              dst_inc,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr,
   output logic [DATA_W-1:0] data_q,
   output logic              cnt_zero,
   output logic              cnt_last
);
   localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

   if (ADDR_W > REG_W || CNT_W > REG_W) begin : g_bad_width
      $error("dma_mover_addr: address and count must fit in REG_W");
   end

   logic [CNT_W-1:0] cnt;
   logic             byte_done;

   assign byte_done = step_fly || step_wr;
   assign cnt_zero  = (cnt == '0);
   assign cnt_last  = (cnt == C_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_addr <= '0;
         dst_addr <= '0;
         cnt      <= '0;
         data_q   <= '0;
      end else begin
         if (load_src) src_addr <= reg_wdata[ADDR_W-1:0];
         else if (step_wr && src_inc) src_addr <= src_addr + A_ONE;

         if (load_dst) dst_addr <= reg_wdata[ADDR_W-1:0];
         else if (step_fly || (step_wr && dst_inc)) dst_addr <= dst_addr + A_ONE;

         if (load_cnt) cnt <= reg_wdata[CNT_W-1:0];
         else if (byte_done) cnt <= cnt - C_ONE;

         if (step_rd) data_q <= rdata;
      end
   end

   assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> (cnt == $past(cnt) - C_ONE));

   assert_fixed_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_wr && !src_inc) |=> $stable(src_addr));

   assert_fixed_dst_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_wr && !dst_inc) |=> $stable(dst_addr));
endmodule

// File: rtl/dma_mover_fsm.sv
`timescale 1ns/1ps
module dma_mover_fsm
   import dma_mover_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  dma_mode_t  mode,
   input  logic       hold_ack,
   input  logic       dev_req,
   input  logic       cnt_last,
   input  logic       cnt_zero,
   output dma_state_t st,
   output logic       hold_req,
   output logic       fly_go,
   output logic       done,
   output logic       busy
);
   dma_state_t nxt;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_IDLE: if (start) nxt = ST_WAIT;
         ST_WAIT: if (mode.two_step || dev_req) nxt = ST_ARB;
         ST_ARB:  if (hold_ack) nxt = mode.two_step ? ST_RD : ST_FLY;
         ST_FLY: begin
            if (dev_req) begin
               if (cnt_last || !mode.burst) nxt = ST_REL;
            end else if (!mode.burst) begin
               nxt = ST_REL;
            end
         end
         ST_RD:   nxt = ST_WR;
         ST_WR:   nxt = (cnt_last || !mode.burst) ? ST_REL : ST_RD;
         ST_REL:  if (!hold_ack) nxt = cnt_zero ? ST_IDLE : ST_WAIT;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nxt;
   end

   assign hold_req = (st == ST_ARB) || (st == ST_FLY) || (st == ST_RD) || (st == ST_WR);
   assign fly_go   = (st == ST_FLY) && dev_req;
   assign done     = (st == ST_REL) && !hold_ack && cnt_zero;
   assign busy     = (st != ST_IDLE);

   assert_steal_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (((st == ST_WR) || fly_go) && !mode.burst) |=> !hold_req);

   assert_burst_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_WR) && mode.burst && !cnt_last) |=> ((st == ST_RD) && hold_req));

   assert_flyby_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_WAIT) && !mode.two_step && !dev_req) |=> !hold_req);
endmodule

// File: rtl/dma_mover.sv
`timescale 1ns/1ps
module dma_mover
   import dma_mover_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int CNT_W        = 16,
   parameter int DATA_W       = 8,
   parameter int REG_W        = 16,
   parameter bit HAS_TWO_STEP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic              irq,
   output logic              busy,
   output logic              hold_req,
   input  logic              hold_ack,
   input  logic              dev_req,
   output logic              dev_ack,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata
);
   if (DATA_W < 1 || CNT_W < 1 || ADDR_W < 1) begin : g_bad_param
      $error("dma_mover: widths must be positive");
   end

   dma_state_t        st;
   dma_mode_t         mode;
   logic              start, done, fly_go, cnt_zero, cnt_last;
   logic [ADDR_W-1:0] src_addr, dst_addr;
   logic [DATA_W-1:0] data_q;
   logic              wr_ok;

   assign wr_ok = reg_we && !busy;

   dma_mover_ctl #(.REG_W(REG_W), .HAS_TWO_STEP(HAS_TWO_STEP)) u_ctl (
      .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .busy, .cnt_zero, .done,
      .start, .mode, .irq
   );

   dma_mover_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_addr (
      .clk, .rst_n,
      .load_src (wr_ok && (reg_sel == SEL_SRC)),
      .load_dst (wr_ok && (reg_sel == SEL_DST)),
      .load_cnt (wr_ok && (reg_sel == SEL_CNT)),
      .reg_wdata,
      .step_fly (fly_go),
      .step_rd  (st == ST_RD),
      .step_wr  (st == ST_WR),
      .src_inc  (mode.src_inc),
      .dst_inc  (mode.dst_inc),
      .rdata    (bus_rdata),
      .src_addr, .dst_addr, .data_q, .cnt_zero, .cnt_last
   );

   dma_mover_fsm u_fsm (
      .clk, .rst_n, .start, .mode, .hold_ack, .dev_req, .cnt_last, .cnt_zero,
      .st, .hold_req, .fly_go, .done, .busy
   );

   always_comb begin
      bus_addr  = '0;
      bus_wdata = '0;
      bus_rd    = 1'b0;
      bus_wr    = 1'b0;
      dev_ack   = fly_go;
      if (st == ST_RD) begin
         bus_addr = src_addr;
         bus_rd   = 1'b1;
      end else if (st == ST_WR) begin
         bus_addr  = dst_addr;
         bus_wdata = data_q;
         bus_wr    = 1'b1;
      end else if (fly_go) begin
         bus_addr = dst_addr;
         bus_rd   = !mode.to_mem;
         bus_wr   = mode.to_mem;
      end
   end

   assert_owned_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr || dev_ack) |-> (hold_req && hold_ack));

   assert_read_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !dev_ack) |=> (bus_wr && !dev_ack));
endmodule

// File: tb/dma_mover_bench.sv
`timescale 1ns/1ps
module dma_mover_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic        irq, busy, hold_req, dev_ack, bus_rd, bus_wr;
   logic        hold_ack = 1'b0;
   logic        dev_req = 1'b1;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata, bus_rdata;

   int checks = 0;
   int errors = 0;
   int grants = 0;
   logic prev_req = 1'b0;
   logic [26:0] exp_q[$];
   logic [26:0] mon_e, mon_a;

   always #10 clk = ~clk;

   assign bus_rdata = bus_addr[7:0] ^ 8'h5A;

   dma_mover u_dma_mover (
      .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .irq, .busy, .hold_req,
      .hold_ack, .dev_req, .dev_ack, .bus_addr, .bus_rd, .bus_wr, .bus_wdata,
      .bus_rdata
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // CPU model and monitor, both on the falling edge
   always @(negedge clk) begin
      hold_ack <= hold_req;
      if (rst_n) begin
         if (hold_req && !prev_req) grants++;
         prev_req <= hold_req;
         if (bus_rd || bus_wr || dev_ack) begin
            mon_a = {bus_rd, bus_wr, dev_ack, bus_addr, bus_wdata};
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 extra bus cycle", int'(mon_a), 0);
            end else begin
               mon_e = exp_q.pop_front();
               check(mon_a == mon_e, "R4/R5/R6 bus cycle", int'(mon_a), int'(mon_e));
            end
         end
      end
   end

   task automatic write_reg(input logic [1:0] sel, input logic [15:0] data);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic logic [15:0] ctl(input bit go, burst, two, sinc, dinc, tomem, clr);
      return {8'd0, clr, 1'b0, tomem, dinc, sinc, two, burst, go};
   endfunction

   task automatic push_block(input logic [15:0] src, dst, input int cnt,
                             input bit two, sinc, dinc, tomem);
      for (int i = 0; i < cnt; i++) begin
         logic [15:0] s, d;
         s = src + (sinc ? 16'(i) : 16'd0);
         d = two ? dst + (dinc ? 16'(i) : 16'd0) : dst + 16'(i);
         if (two) begin
            exp_q.push_back({1'b1, 1'b0, 1'b0, s, 8'd0});
            exp_q.push_back({1'b0, 1'b1, 1'b0, d, s[7:0] ^ 8'h5A});
         end else begin
            exp_q.push_back({!tomem, tomem, 1'b1, d, 8'd0});
         end
      end
   endtask

   task automatic finish_block(input string tag, input int base, input int exp_grants);
      int n = 0;
      while (!irq && n < 3000) begin @(negedge clk); n++; end
      check(irq == 1'b1, {tag, " R7 irq at end"}, irq, 1);
      check(busy == 1'b0, {tag, " R7 idle at end"}, busy, 0);
      check(exp_q.size() == 0, {tag, " R7 all bytes moved"}, exp_q.size(), 0);
      check(grants - base == exp_grants, {tag, " R2/R3 grant count"}, grants - base, exp_grants);
      repeat (3) @(negedge clk);
      check(irq == 1'b1, {tag, " R8 irq held"}, irq, 1);
      write_reg(2'd3, ctl(0, 0, 0, 0, 0, 0, 1));
      check(irq == 1'b0, {tag, " R8 irq cleared"}, irq, 0);
   endtask

   task automatic run(input string tag, input logic [15:0] src, dst, input int cnt,
                      input bit burst, two, sinc, dinc, tomem, input bit poke);
      int base;
      write_reg(2'd0, src);
      write_reg(2'd1, dst);
      write_reg(2'd2, 16'(cnt));
      push_block(src, dst, cnt, two, sinc, dinc, tomem);
      base = grants;
      write_reg(2'd3, ctl(1, burst, two, sinc, dinc, tomem, 0));
      if (poke) begin
         // R10: writes during a transfer must not disturb it
         check(busy == 1'b1, "R10 busy during poke", busy, 1);
         write_reg(2'd0, 16'h9000);
         write_reg(2'd2, 16'd40);
         write_reg(2'd3, ctl(1, 0, 0, 0, 0, 1, 0));
      end
      finish_block(tag, base, (cnt == 0) ? 0 : (burst ? 1 : cnt));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      check({hold_req, irq, busy, bus_rd, bus_wr, dev_ack} == 6'd0, "R1 reset state",
            {hold_req, irq, busy, bus_rd, bus_wr, dev_ack}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(hold_req == 1'b0, "R1 no request before start", hold_req, 0);

      run("burst two-cycle", 16'h0100, 16'h2000, 4, 1, 1, 1, 1, 0, 0);
      run("steal two-cycle port src", 16'h0380, 16'h3000, 3, 0, 1, 0, 1, 0, 0);
      run("burst two-cycle fixed dst", 16'h0040, 16'h0390, 3, 1, 1, 1, 0, 0, 0);
      run("burst fly-by to mem", 16'h0000, 16'h4000, 3, 1, 0, 0, 0, 1, 0);
      run("steal fly-by from mem", 16'h0000, 16'h5010, 2, 0, 0, 0, 0, 0, 0);
      run("R10 busy writes", 16'h0200, 16'h6000, 4, 1, 1, 1, 1, 0, 1);

      // R9: zero count finishes at once
      base = grants;
      write_reg(2'd2, 16'd0);
      write_reg(2'd3, ctl(1, 1, 1, 1, 1, 0, 0));
      check(irq == 1'b1, "R9 irq on zero count", irq, 1);
      check(busy == 1'b0, "R9 not busy", busy, 0);
      repeat (5) @(negedge clk);
      check(grants == base, "R9 no grant", grants - base, 0);
      write_reg(2'd3, ctl(0, 0, 0, 0, 0, 0, 1));
      check(irq == 1'b0, "R8 clear after zero start", irq, 0);

      // R11: fly-by stalls until the device asks
      dev_req = 1'b0;
      write_reg(2'd0, 16'h0000);
      write_reg(2'd1, 16'h7000);
      write_reg(2'd2, 16'd2);
      push_block(16'h0000, 16'h7000, 2, 0, 0, 0, 1);
      base = grants;
      write_reg(2'd3, ctl(1, 0, 0, 0, 0, 1, 0));
      repeat (10) @(negedge clk);
      check(grants == base, "R11 no request without dev_req", grants - base, 0);
      check(busy == 1'b1, "R11 waiting busy", busy, 1);
      check(exp_q.size() == 2, "R11 no byte moved yet", exp_q.size(), 2);
      dev_req = 1'b1;
      finish_block("R11 resumed", base, 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule